// File: doc/BRIEF.md
# Floating-Point Format Widener

This block takes a narrow floating-point word and returns the same value as a 64-bit double-precision bit pattern. No precision is lost, so no rounding is needed. By default it widens half-precision words. One parameter change makes the same logic widen single-precision words.

A word is presented with a valid strobe. The widened word and its valid flag appear on the registered outputs after the next rising clock edge. Every input class is handled:

- Signed zeros keep their sign.
- Subnormal inputs become ordinary normal doubles. A leading-one detector and a shifter do this in one cycle.
- Infinities stay infinities.
- NaN payloads are moved to the top of the wide fraction, so the quiet/signalling bit keeps its place.

Top module: `fwiden`

## Requirements
- R1: For a normal input (exponent neither 0 nor all ones), the output exponent is the input exponent plus (wide bias − narrow bias). The output fraction is the input fraction shifted left by (wide fraction width − narrow fraction width). Default layout, narrow: sign bit 15, exponent bits 14:10, fraction bits 9:0, bias 15. Default layout, wide: sign bit 63, exponent bits 62:52, fraction bits 51:0, bias 1023. Example: 0x3C00 gives 0x3FF0000000000000.
- R2: An input whose exponent and fraction are both zero gives a wide zero with the same sign. 0x8000 gives 0x8000000000000000.
- R3: A subnormal input (exponent 0, fraction nonzero) gives a normal output. Let p be the index of the highest set fraction bit. The output exponent is (wide bias − narrow bias − narrow fraction width + 1 + p). The output fraction holds the fraction bits below p, left-aligned. Examples: 0x0001 gives 0x3E70000000000000, and 0x03FF gives 0x3F0FF80000000000.
- R4: An input with an all-ones exponent and zero fraction gives an infinity of the same sign. 0xFC00 gives 0xFFF0000000000000.
- R5: An input with an all-ones exponent and nonzero fraction gives an all-ones output exponent. Its fraction is shifted left as in R1, so the output remains a NaN with the top fraction bit kept. 0x7E00 gives 0x7FF8000000000000, and 0x7C01 gives 0x7FF0040000000000.
- R6: The output sign bit always equals the input sign bit.
- R7: outValid after a rising edge equals inValid sampled at that edge. outWord holds the widened value of the word captured at that edge.
- R8: While inValid is low at an edge, outWord keeps its previous value.
- R9: While rst is high at an edge, outValid and outWord are cleared to zero.
- R10: With 8 exponent bits, 23 fraction bits and bias 127 on the narrow side, the same rules apply. 0x3F800000 gives 0x3FF0000000000000, 0x00000001 gives 0x36A0000000000000, and 0x807FFFFF gives 0xB80FFFFFC0000000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Strobe qualifying inWord |
| inWord | input | 1+NARROW_EXP+NARROW_FRAC (16) | Narrow floating-point word |
| outValid | output | 1 | Registered strobe, one cycle after inValid |
| outWord | output | 1+WIDE_EXP+WIDE_FRAC (64) | Widened floating-point word |

## Verification
The assertions check on every cycle:
- the one-cycle valid relationship;
- that the output holds when no strobe arrives;
- that the sign is preserved;
- the coarse class mapping: zeros stay zero, specials keep an all-ones exponent, and subnormals land on a nonzero, non-special exponent.

The assertions cannot show the exact exponent and fraction bits of normalised subnormals or left-aligned NaN payloads. The bench shows these by sweeping every half-precision code against an iterative reference model, running directed single-precision cases, and running hold and reset scenarios.

// File: rtl/fwiden_pkg.sv
package fwiden_pkg;

  // Strobes from control to datapath.
  typedef struct packed {
    logic capture;  // load a new widened value this edge
    logic clear;    // synchronous clear of the output register
  } fwidenStrobe_t;

  // Input classes that select the datapath mapping.
  typedef enum logic [1:0] {
    CLS_ZERO    = 2'd0,
    CLS_SUB     = 2'd1,
    CLS_NORM    = 2'd2,
    CLS_SPECIAL = 2'd3
  } fwidenClass_t;

endpackage

// File: rtl/fwiden_lzc.sv
// Priority detector: index of the highest set bit of vec (0 when vec is zero).
module fwiden_lzc #(
  parameter int W = 10,
  localparam int PW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  vec,
  output logic [PW-1:0] pos
);

  always_comb begin
    pos = '0;
    for (int i = 0; i < W; i++) begin
      if (vec[i]) pos = PW'(i);
    end
  end

endmodule

// File: rtl/fwiden_ctrl.sv
module fwiden_ctrl
  import fwiden_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          inValid,
  output fwidenStrobe_t strobe,
  output logic          outValid
);

  always_comb begin
    strobe.capture = inValid & ~rst;
    strobe.clear   = rst;
  end

  always_ff @(posedge clk) begin
    if (rst) outValid <= 1'b0;
    else     outValid <= inValid;
  end

  // R7: valid follows the input strobe by exactly one edge
  a_r7_valid_set: assert property (@(posedge clk) disable iff (rst)
    inValid |=> outValid);
  a_r7_valid_clr: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> !outValid);
  // R9: reset clears the valid flag
  a_r9_reset_valid: assert property (@(posedge clk)
    rst |=> !outValid);

endmodule

// File: rtl/fwiden_dp.sv
module fwiden_dp
  import fwiden_pkg::*;
#(
  parameter int NE = 5,
  parameter int NF = 10,
  parameter int WE = 11,
  parameter int WF = 52
) (
  input  logic            clk,
  input  fwidenStrobe_t   strobe,
  input  logic [NE+NF:0]  inWord,
  output logic [WE+WF:0]  outWord
);

  localparam int NBIAS    = (1 << (NE - 1)) - 1;
  localparam int WBIAS    = (1 << (WE - 1)) - 1;
  localparam int REBIAS   = WBIAS - NBIAS;
  localparam int SUB_BASE = REBIAS - NF + 1;
  localparam int FSHIFT   = WF - NF;
  localparam int PW       = (NF > 1) ? $clog2(NF) : 1;
  localparam int SAW      = $clog2(WF + 1);

  logic           sgn;
  logic [NE-1:0]  nExp;
  logic [NF-1:0]  nFrac;
  fwidenClass_t   cls;
  logic [PW-1:0]  leadPos;
  logic [SAW-1:0] subAmt;
  logic [WF:0]    subWide;
  logic [WE-1:0]  wExp;
  logic [WF-1:0]  wFrac;

  assign sgn   = inWord[NE+NF];
  assign nExp  = inWord[NE+NF-1:NF];
  assign nFrac = inWord[NF-1:0];

  always_comb begin
    if (nExp == '0)      cls = (nFrac == '0) ? CLS_ZERO : CLS_SUB;
    else if (&nExp)      cls = CLS_SPECIAL;
    else                 cls = CLS_NORM;
  end

  fwiden_lzc #(.W(NF)) u_lzc (
    .vec (nFrac),
    .pos (leadPos)
  );

  // Move the leading one to bit WF; truncation to WF bits drops it.
  assign subAmt  = SAW'(WF) - SAW'(leadPos);
  assign subWide = {{(WF + 1 - NF){1'b0}}, nFrac} << subAmt;

  always_comb begin
    wExp  = '0;
    wFrac = '0;
    case (cls)
      CLS_ZERO: begin
        wExp  = '0;
        wFrac = '0;
      end
      CLS_SUB: begin
        wExp  = WE'(SUB_BASE) + WE'(leadPos);
        wFrac = subWide[WF-1:0];
      end
      CLS_NORM: begin
        wExp  = WE'(nExp) + WE'(REBIAS);
        wFrac = {nFrac, {FSHIFT{1'b0}}};
      end
      CLS_SPECIAL: begin
        wExp  = '1;
        wFrac = {nFrac, {FSHIFT{1'b0}}};
      end
      default: begin
        wExp  = '0;
        wFrac = '0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (strobe.clear)        outWord <= '0;
    else if (strobe.capture) outWord <= {sgn, wExp, wFrac};
  end

  // R8: no capture, no change
  a_r8_hold: assert property (@(posedge clk) disable iff (strobe.clear)
    !strobe.capture |=> $stable(outWord));
  // R6: sign carried through
  a_r6_sign: assert property (@(posedge clk) disable iff (strobe.clear)
    strobe.capture |=> outWord[WE+WF] == $past(inWord[NE+NF]));
  // R2: zero in, zero magnitude out
  a_r2_zero: assert property (@(posedge clk) disable iff (strobe.clear)
    (strobe.capture && inWord[NE+NF-1:0] == '0) |=> outWord[WE+WF-1:0] == '0);
  // R4/R5: specials keep an all-ones exponent
  a_r5_special_exp: assert property (@(posedge clk) disable iff (strobe.clear)
    (strobe.capture && (&inWord[NE+NF-1:NF])) |=> (&outWord[WE+WF-1:WF]));
  // R3: subnormals become normal wide numbers
  a_r3_sub_normal: assert property (@(posedge clk) disable iff (strobe.clear)
    (strobe.capture && inWord[NE+NF-1:NF] == '0 && inWord[NF-1:0] != '0)
      |=> (outWord[WE+WF-1:WF] != '0 && !(&outWord[WE+WF-1:WF])));
  // R9: reset clears the data register
  a_r9_reset_word: assert property (@(posedge clk)
    strobe.clear |=> outWord == '0);

endmodule

// File: rtl/fwiden.sv
module fwiden
  import fwiden_pkg::*;
#(
  parameter int NARROW_EXP  = 5,
  parameter int NARROW_FRAC = 10,
  parameter int WIDE_EXP    = 11,
  parameter int WIDE_FRAC   = 52
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            inValid,
  input  logic [NARROW_EXP+NARROW_FRAC:0] inWord,
  output logic                            outValid,
  output logic [WIDE_EXP+WIDE_FRAC:0]     outWord
);

  fwidenStrobe_t strobe;

  fwiden_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .strobe   (strobe),
    .outValid (outValid)
  );

  fwiden_dp #(
    .NE (NARROW_EXP),
    .NF (NARROW_FRAC),
    .WE (WIDE_EXP),
    .WF (WIDE_FRAC)
  ) u_dp (
    .clk     (clk),
    .strobe  (strobe),
    .inWord  (inWord),
    .outWord (outWord)
  );

endmodule

// File: tb/fwiden_tb.sv
module fwiden_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        inValid = 1'b0;
  logic [15:0] inWord = '0;
  logic        outValid;
  logic [63:0] outWord;

  logic        inValid32 = 1'b0;
  logic [31:0] inWord32 = '0;
  logic        outValid32;
  logic [63:0] outWord32;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  fwiden u_dut (
    .clk(clk), .rst(rst), .inValid(inValid), .inWord(inWord),
    .outValid(outValid), .outWord(outWord)
  );

  fwiden #(.NARROW_EXP(8), .NARROW_FRAC(23), .WIDE_EXP(11), .WIDE_FRAC(52)) u_dut32 (
    .clk(clk), .rst(rst), .inValid(inValid32), .inWord(inWord32),
    .outValid(outValid32), .outWord(outWord32)
  );

  // Iterative reference: normalise subnormals one place at a time.
  function automatic logic [63:0] refWiden(input logic [63:0] x, input int e, input int f);
    longint unsigned sgn, ex, fr, m, we, maxE;
    int nb;
    nb   = (1 << (e - 1)) - 1;
    maxE = (64'd1 << e) - 1;
    sgn  = (x >> (e + f)) & 1;
    ex   = (x >> f) & maxE;
    fr   = x & ((64'd1 << f) - 1);
    if (ex == 0 && fr == 0) begin
      we = 0; m = 0;
    end else if (ex == 0) begin
      we = 1023 - nb;
      m  = fr << (53 - f);
      while (((m >> 52) & 1) == 0) begin
        m  = m << 1;
        we = we - 1;
      end
    end else if (ex == maxE) begin
      we = 2047; m = fr << (52 - f);
    end else begin
      we = ex + 1023 - nb; m = fr << (52 - f);
    end
    return (sgn << 63) | ((we & 64'h7FF) << 52) | (m & 64'h000F_FFFF_FFFF_FFFF);
  endfunction

  function automatic string tagOf(input logic [15:0] w);
    if (w[14:0] == 0)      return "R2";
    if (w[14:10] == 0)     return "R3";
    if (&w[14:10])         return (w[9:0] == 0) ? "R4" : "R5";
    return "R1";
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Cycle-by-cycle model of the half-precision instance.
  logic        modelValid = 1'b0;
  logic [63:0] modelWord  = '0;
  string       modelTag   = "R9";

  always @(posedge clk) begin
    if (rst) begin
      modelValid <= 1'b0;
      modelWord  <= '0;
      modelTag   <= "R9";
    end else begin
      modelValid <= inValid;
      if (inValid) begin
        modelWord <= refWiden({48'd0, inWord}, 5, 10);
        modelTag  <= tagOf(inWord);
      end else begin
        modelTag <= "R8";
      end
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      check("R7", {63'd0, outValid}, {63'd0, modelValid});
      check(modelTag, outWord, modelWord);
    end
  end

  task automatic drive(input logic v, input logic [15:0] w);
    @(negedge clk);
    inValid = v;
    inWord  = w;
  endtask

  task automatic directed(input string tag, input logic [15:0] w, input logic [63:0] exp);
    drive(1'b1, w);
    @(negedge clk);
    #1 check(tag, outWord, exp);
  endtask

  task automatic directed32(input string tag, input logic [31:0] w, input logic [63:0] exp);
    @(negedge clk);
    inValid32 = 1'b1;
    inWord32  = w;
    @(negedge clk);
    #1;
    check(tag, outWord32, exp);
    check(tag, outWord32, refWiden({32'd0, w}, 8, 23));
    check(tag, {63'd0, outValid32}, 64'd1);
  endtask

  task automatic finish();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(8 * 190000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check("R9", {63'd0, outValid}, 64'd0);
    check("R9", outWord, 64'd0);
    @(negedge clk);
    rst = 1'b0;

    directed("R1", 16'h3C00, 64'h3FF0000000000000);
    directed("R1", 16'h7BFF, 64'h40EFFC0000000000);
    directed("R1", 16'h0400, 64'h3F10000000000000);
    directed("R2", 16'h0000, 64'h0000000000000000);
    directed("R2", 16'h8000, 64'h8000000000000000);
    directed("R3", 16'h0001, 64'h3E70000000000000);
    directed("R3", 16'h03FF, 64'h3F0FF80000000000);
    directed("R3", 16'h0200, 64'h3F00000000000000);
    directed("R6", 16'h8001, 64'hBE70000000000000);
    directed("R4", 16'h7C00, 64'h7FF0000000000000);
    directed("R4", 16'hFC00, 64'hFFF0000000000000);
    directed("R5", 16'h7E00, 64'h7FF8000000000000);
    directed("R5", 16'h7C01, 64'h7FF0040000000000);

    // R8: idle cycles with a changing input leave the output alone
    directed("R8", 16'h3C00, 64'h3FF0000000000000);
    drive(1'b0, 16'h7C00);
    repeat (3) @(negedge clk);
    #1 check("R8", outWord, 64'h3FF0000000000000);
    inWord = 16'h8001;
    @(negedge clk);
    #1 check("R8", outWord, 64'h3FF0000000000000);

    // R10: single-precision parameter set
    directed32("R10", 32'h3F800000, 64'h3FF0000000000000);
    directed32("R10", 32'h00000001, 64'h36A0000000000000);
    directed32("R10", 32'h807FFFFF, 64'hB80FFFFFC0000000);
    directed32("R10", 32'h7FC00000, 64'h7FF8000000000000);

    // Exhaustive sweep of every half-precision code (R1..R6)
    for (int i = 0; i < 65536; i++) drive(1'b1, 16'(i));

    // Gapped random traffic (R7, R8)
    for (int i = 0; i < 4000; i++) drive(1'($urandom_range(0, 1)), 16'($urandom));

    // Mid-stream reset (R9)
    drive(1'b1, 16'h3C00);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    #1;
    check("R9", outWord, 64'd0);
    check("R9", {63'd0, outValid}, 64'd0);
    rst = 1'b0;
    drive(1'b0, 16'h0000);
    repeat (2) @(negedge clk);
    finish();
  end

endmodule